// File: doc/BRIEF.md
# Vertical Ramp Generator with Automatic Gain Control

This block produces the digital vertical sawtooth for a scanning display. An accumulator starts each sweep at a fixed bottom code and adds a step value on every clock. At the end of the sweep the block enters a fixed-length retrace, during which the ramp is held at the bottom code. It then starts again. With no vertical sync present the block free-runs: each sweep ends when the ramp reaches the top code, so the base step alone sets the nominal rate.

A single-cycle, already conditioned vertical sync pulse ends the sweep early when it arrives inside a capture window. The window opens at 2/5 of the free-running sweep length and closes at three times that length. This corresponds to sync rates from about 0.33 to 2.5 times the free-running rate. The first accepted sync puts the block into the locked condition.

While locked, the ramp value reached at each sync is taken as the peak of that sweep. A proportional gain loop then corrects the step for the next sweep, so the peak-to-peak amplitude returns to the nominal value after a change in sync rate. If a locked sweep reaches the end of the window without a sync, lock is dropped, the base step is restored and free-running resumes.

With defaults: full scale 4096, bottom 1024, top 2560, midpoint 1792, step in 1/256 code units (base 1536), free sweep 256 clocks, window counts 102 to 767, retrace 16 clocks.

The controller has two states:
- ST_CHARGE leaves for ST_RETRACE on one of three transitions:
  - top reached while unlocked (free end);
  - an accepted sync (sync end);
  - the window count running out while locked (timeout end).
- ST_RETRACE returns to ST_CHARGE once its clock count is used up.

Top module: `vramp_agc_gen`

## Requirements
- R1: The bottom code is one quarter of full scale. The ramp output equals the bottom code in reset, during retrace and in the first charge clock, and it is never below the bottom code.
- R2: Unlocked, the ramp after k charge clocks equals (bottom·256 + k·BASE_STEP)/256, truncated. The sweep ends on the clock where the ramp is at or above the top code (5/8 of full scale), so a free sweep shows FREE_CLKS+1 samples.
- R3: A retrace flag is high for exactly RETRACE_CLKS clocks after every sweep end, with the ramp held at bottom.
- R4: A sync pulse seen on a charge clock whose count c satisfies WIN_LO ≤ c < WIN_HI ends the sweep on that clock and sets lock. A sync seen with c below WIN_LO is ignored and the sweep runs on.
- R5: A sync pulse during retrace is ignored: the retrace length and the next sweep start are unchanged.
- R6: On each sync end the step changes by (top − peak) arithmetically shifted right by GAIN_SH, clamped to ±MAX_DELTA. In steady sync the peak settles within TOL of the top code.
- R7: The step never leaves [STEP_MIN, STEP_MAX]. A sync rate that needs a smaller step runs at STEP_MIN slope.
- R8: Once settled, the ramp midpoint (bottom+peak)/2 lies within TOL of 7/16 of full scale whatever the sync rate.
- R9: The settled flag is low after reset. It rises after four consecutive sweep ends whose peak is within TOL of top. An out-of-tolerance peak or a timeout end clears it.
- R10: Locked with no accepted sync, the sweep ends when its count reaches WIN_HI−1, giving WIN_HI samples. The step then returns to BASE_STEP and free sweeps resume.
- R11: Locked, the spacing between retrace starts equals the sync spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_pulse | input | 1 | Conditioned one-clock vertical sync |
| ramp_code | output | RAMP_W | Ramp value |
| retrace | output | 1 | High during discharge |
| agc_settled | output | 1 | Amplitude loop within tolerance |

## Verification
The bench goes after the following corner cases:
- A sync below the capture window. A design that accepted it would cut the free sweep short.
- A sync inside retrace. A design that honoured it would stretch or restart the discharge.
- A jump to a sync rate that needs less than the minimum step. A design without the clamp would flatten the slope below STEP_MIN.
- Loss of sync. A design that kept the locked step would free-run at the wrong rate.

Random sync rates check that the peak converges, that the midpoint stays put, and that the sweep-to-sweep slope change respects the per-cycle clamp. A loop with the wrong sign or gain would drift or oscillate.

// File: rtl/vramp_pkg.sv
package vramp_pkg;

    typedef enum logic [0:0] {
        ST_CHARGE  = 1'b0,
        ST_RETRACE = 1'b1
    } vr_state_e;

    typedef enum logic [1:0] {
        END_NONE    = 2'd0,
        END_TOP     = 2'd1,
        END_SYNC    = 2'd2,
        END_TIMEOUT = 2'd3
    } vr_end_e;

endpackage

// File: rtl/vramp_sweep_fsm.sv
module vramp_sweep_fsm
    import vramp_pkg::*;
#(
    parameter int RAMP_W       = 12,
    parameter int FRAC_W       = 8,
    parameter int STEP_W       = 13,
    parameter int BOTTOM_CODE  = 1024,
    parameter int TOP_CODE     = 2560,
    parameter int RETRACE_CLKS = 16,
    parameter int WIN_LO       = 102,
    parameter int WIN_HI       = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_pulse,
    input  logic [STEP_W-1:0] step,
    output logic [RAMP_W-1:0] ramp_code,
    output logic              retrace,
    output vr_end_e           end_kind
);

    localparam int ACC_W = RAMP_W + FRAC_W;
    localparam int CNT_W = $clog2(WIN_HI + 1);
    localparam int RT_W  = $clog2(RETRACE_CLKS + 1);
    localparam logic [ACC_W-1:0]  ACC_BOT = ACC_W'(BOTTOM_CODE) << FRAC_W;
    localparam logic [RAMP_W-1:0] TOP_C   = RAMP_W'(TOP_CODE);
    localparam logic [RAMP_W-1:0] BOT_C   = RAMP_W'(BOTTOM_CODE);
    localparam logic [CNT_W-1:0]  LO_C    = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0]  HI_C    = CNT_W'(WIN_HI);
    localparam logic [CNT_W-1:0]  HI_LAST = CNT_W'(WIN_HI - 1);
    localparam logic [RT_W-1:0]   RT_LAST = RT_W'(RETRACE_CLKS - 1);

    vr_state_e         state_q, state_d;
    logic [ACC_W-1:0]  acc_q, acc_inc;
    logic [ACC_W:0]    acc_sum;
    logic [CNT_W-1:0]  cnt_q;
    logic [RT_W-1:0]   rt_q;
    logic              lock_q;
    logic              in_window, sync_ok, hit_top, tmo_hit, rt_last;

    // Saturating charge step
    always_comb begin
        acc_sum = {1'b0, acc_q} + (ACC_W+1)'(step);
        acc_inc = acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
    end

    // Sweep-end decoding: sync has priority, then timeout, then free top
    always_comb begin
        in_window = (cnt_q >= LO_C) && (cnt_q < HI_C);
        sync_ok   = vsync_pulse && (state_q == ST_CHARGE) && in_window;
        hit_top   = !lock_q && (ramp_code >= TOP_C);
        tmo_hit   = lock_q && (cnt_q >= HI_LAST);
        rt_last   = (rt_q == RT_LAST);
        if (state_q != ST_CHARGE) end_kind = END_NONE;
        else if (sync_ok)         end_kind = END_SYNC;
        else if (tmo_hit)         end_kind = END_TIMEOUT;
        else if (hit_top)         end_kind = END_TOP;
        else                      end_kind = END_NONE;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHARGE:  state_d = (end_kind != END_NONE) ? ST_RETRACE : ST_CHARGE;
            ST_RETRACE: state_d = rt_last ? ST_CHARGE : ST_RETRACE;
            default:    state_d = ST_CHARGE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CHARGE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_BOT;
            cnt_q  <= '0;
            rt_q   <= '0;
            lock_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CHARGE: begin
                    if (end_kind != END_NONE) begin
                        acc_q <= ACC_BOT;
                        cnt_q <= '0;
                        rt_q  <= '0;
                        if (end_kind == END_SYNC)    lock_q <= 1'b1;
                        if (end_kind == END_TIMEOUT) lock_q <= 1'b0;
                    end else begin
                        acc_q <= acc_inc;
                        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RETRACE: rt_q <= rt_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        ramp_code = acc_q[ACC_W-1:FRAC_W];
        retrace   = (state_q == ST_RETRACE);
    end

    AST_RAMP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_code >= BOT_C); // R1
    AST_CHARGE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE && $past(state_q) == ST_CHARGE) |-> ramp_code >= $past(ramp_code)); // R2
    AST_RETRACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        retrace |-> ramp_code == BOT_C); // R3
    AST_LOCK_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (end_kind == END_SYNC) |=> lock_q); // R4
    AST_RETRACE_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (retrace && !rt_last) |=> retrace); // R5

endmodule

// File: rtl/vramp_agc_loop.sv
module vramp_agc_loop
    import vramp_pkg::*;
#(
    parameter int RAMP_W    = 12,
    parameter int STEP_W    = 13,
    parameter int TOP_CODE  = 2560,
    parameter int BASE_STEP = 1536,
    parameter int STEP_MIN  = 1024,
    parameter int STEP_MAX  = 4096,
    parameter int MAX_DELTA = 256,
    parameter int GAIN_SH   = 1,
    parameter int TOL       = 8,
    parameter int SETTLE_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vr_end_e           end_kind,
    input  logic [RAMP_W-1:0] peak,
    output logic [STEP_W-1:0] step,
    output logic              settled
);

    localparam int W      = ((STEP_W > RAMP_W) ? STEP_W : RAMP_W) + 2;
    localparam int GOOD_W = $clog2(SETTLE_N + 1);
    localparam logic signed [W-1:0] TOP_S  = W'(TOP_CODE);
    localparam logic signed [W-1:0] DMAX_S = W'(MAX_DELTA);
    localparam logic signed [W-1:0] DMIN_S = -DMAX_S;
    localparam logic signed [W-1:0] SMIN_S = W'(STEP_MIN);
    localparam logic signed [W-1:0] SMAX_S = W'(STEP_MAX);
    localparam logic signed [W-1:0] TOL_S  = W'(TOL);
    localparam logic [STEP_W-1:0]   BASE_C = STEP_W'(BASE_STEP);
    localparam logic [STEP_W-1:0]   SMIN_C = STEP_W'(STEP_MIN);
    localparam logic [STEP_W-1:0]   SMAX_C = STEP_W'(STEP_MAX);
    localparam logic [STEP_W-1:0]   DMAX_C = STEP_W'(MAX_DELTA);
    localparam logic [GOOD_W-1:0]   GOOD_N = GOOD_W'(SETTLE_N);

    logic [STEP_W-1:0]   step_q, step_nxt;
    logic [GOOD_W-1:0]   good_q;
    logic signed [W-1:0] err_s, dlt_raw, dlt, sum_s, err_abs;
    logic                in_tol;

    always_comb begin
        err_s   = TOP_S - $signed({{(W-RAMP_W){1'b0}}, peak});
        dlt_raw = err_s >>> GAIN_SH;
        if (dlt_raw > DMAX_S)      dlt = DMAX_S;
        else if (dlt_raw < DMIN_S) dlt = DMIN_S;
        else                       dlt = dlt_raw;
        sum_s = $signed({{(W-STEP_W){1'b0}}, step_q}) + dlt;
        if (sum_s < SMIN_S)      step_nxt = SMIN_C;
        else if (sum_s > SMAX_S) step_nxt = SMAX_C;
        else                     step_nxt = sum_s[STEP_W-1:0];
        err_abs = err_s[W-1] ? -err_s : err_s;
        in_tol  = (err_abs <= TOL_S);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= BASE_C;
            good_q <= '0;
        end else begin
            unique case (end_kind)
                END_SYNC: begin
                    step_q <= step_nxt;
                    good_q <= in_tol ? ((good_q == GOOD_N) ? good_q : good_q + 1'b1) : '0;
                end
                END_TOP: good_q <= in_tol ? ((good_q == GOOD_N) ? good_q : good_q + 1'b1) : '0;
                END_TIMEOUT: begin
                    step_q <= BASE_C;
                    good_q <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        step    = step_q;
        settled = (good_q == GOOD_N);
    end

    AST_STEP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q >= SMIN_C) && (step_q <= SMAX_C)); // R7
    AST_STEP_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(end_kind) != END_TIMEOUT) |->
        (((step_q >= $past(step_q)) ? (step_q - $past(step_q)) : ($past(step_q) - step_q)) <= DMAX_C)); // R6
    AST_BASE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (end_kind == END_TIMEOUT) |=> (step_q == BASE_C)); // R10
    AST_SETTLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> ($past(end_kind) != END_NONE)); // R9

endmodule

// File: rtl/vramp_agc_gen.sv
module vramp_agc_gen
    import vramp_pkg::*;
#(
    parameter int RAMP_W       = 12,
    parameter int FRAC_W       = 8,
    parameter int BASE_STEP    = 1536,
    parameter int STEP_MIN     = 1024,
    parameter int STEP_MAX     = 4096,
    parameter int MAX_DELTA    = 256,
    parameter int GAIN_SH      = 1,
    parameter int RETRACE_CLKS = 16,
    parameter int TOL          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_pulse,
    output logic [RAMP_W-1:0] ramp_code,
    output logic              retrace,
    output logic              agc_settled
);

    localparam int FULL      = 1 << RAMP_W;
    localparam int BOTTOM    = FULL / 4;
    localparam int TOP       = (FULL * 5) / 8;
    localparam int AMP       = TOP - BOTTOM;
    localparam int FREE_CLKS = ((AMP << FRAC_W) + BASE_STEP - 1) / BASE_STEP;
    localparam int WIN_LO    = (FREE_CLKS * 2) / 5;
    localparam int WIN_HI    = FREE_CLKS * 3;
    localparam int STEP_W    = $clog2(STEP_MAX + 1);

    logic [STEP_W-1:0] step;
    vr_end_e           end_kind;

    vramp_sweep_fsm #(
        .RAMP_W(RAMP_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W),
        .BOTTOM_CODE(BOTTOM), .TOP_CODE(TOP), .RETRACE_CLKS(RETRACE_CLKS),
        .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) i_sweep (
        .clk(clk), .rst_n(rst_n), .vsync_pulse(vsync_pulse), .step(step),
        .ramp_code(ramp_code), .retrace(retrace), .end_kind(end_kind)
    );

    vramp_agc_loop #(
        .RAMP_W(RAMP_W), .STEP_W(STEP_W), .TOP_CODE(TOP), .BASE_STEP(BASE_STEP),
        .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .MAX_DELTA(MAX_DELTA),
        .GAIN_SH(GAIN_SH), .TOL(TOL), .SETTLE_N(4)
    ) i_agc (
        .clk(clk), .rst_n(rst_n), .end_kind(end_kind), .peak(ramp_code),
        .step(step), .settled(agc_settled)
    );

    AST_END_STARTS_RETRACE: assert property (@(posedge clk) disable iff (!rst_n)
        (end_kind != END_NONE) |=> retrace); // R3

endmodule

// File: tb/test_vramp_agc_gen.sv
module test_vramp_agc_gen;

    localparam int RAMP_W = 12, FRAC_W = 8, BASE = 1536, SMIN = 1024;
    localparam int MAXD = 256, RT = 16, TOL = 8;
    localparam int FULL = 1 << RAMP_W;
    localparam int BOTTOM = FULL / 4, TOP = FULL * 5 / 8, MID = FULL * 7 / 16;
    localparam int FREE = (((TOP - BOTTOM) << FRAC_W) + BASE - 1) / BASE;
    localparam int WHI = FREE * 3;

    logic clk = 1'b0, rst_n = 1'b0, vsync = 1'b0;
    logic [RAMP_W-1:0] ramp;
    logic retrace, settled;

    int checks = 0, fails = 0, cyc = 0;
    int prev_ret = 0, prev_ramp = 0, charge_run = 0, ret_run = 0;
    int last_peak = 0, last_charge = 0, last_ret = 0, first_after = 0;
    int rise_t = 0, prev_rise = 0, nrise = 0, nfall = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vramp_agc_gen i_vramp_agc_gen (
        .clk(clk), .rst_n(rst_n), .vsync_pulse(vsync),
        .ramp_code(ramp), .retrace(retrace), .agc_settled(settled)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int free_ramp(input int k);
        return (BOTTOM * 256 + k * BASE) >>> FRAC_W;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic vs);
        vsync = vs;
        @(posedge clk);
        #1;
        vsync = 1'b0;
        cyc++;
        if (retrace && prev_ret == 0) begin
            last_peak = prev_ramp; last_charge = charge_run;
            prev_rise = rise_t; rise_t = cyc; nrise++;
        end
        if (!retrace && prev_ret != 0) begin
            last_ret = ret_run; first_after = int'(ramp); nfall++;
        end
        if (retrace) begin
            ret_run = (prev_ret != 0) ? ret_run + 1 : 1;
            charge_run = 0;
        end else charge_run++;
        prev_ret = retrace ? 1 : 0;
        prev_ramp = int'(ramp);
    endtask

    task automatic wait_rise();
        int n0 = nrise;
        while (nrise == n0) tick(1'b0);
    endtask

    task automatic wait_fall();
        int n0 = nfall;
        while (nfall == n0) tick(1'b0);
    endtask

    task automatic run_sync(input int per, input int n);
        for (int i = 0; i < n; i++) begin
            repeat (per - 1) tick(1'b0);
            tick(1'b1);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int bad, per, prev_est, est, sbad;
        bit have_prev;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1;
        chk(int'(ramp) == BOTTOM, "R1 reset ramp", int'(ramp), BOTTOM);
        chk(retrace == 1'b0, "R3 reset retrace", int'(retrace), 0);
        chk(settled == 1'b0, "R9 reset settled", int'(settled), 0);
        rst_n = 1'b1;

        // Free run
        repeat (5) wait_rise();
        chk(last_charge == FREE + 1, "R2 free sweep length", last_charge, FREE + 1);
        chk(last_peak == TOP, "R2 free peak", last_peak, TOP);
        chk(rise_t - prev_rise == FREE + 1 + RT, "R2 free period", rise_t - prev_rise, FREE + 1 + RT);
        chk(last_ret == RT, "R3 retrace length", last_ret, RT);
        chk(first_after == BOTTOM, "R1 sweep start", first_after, BOTTOM);
        chk(settled == 1'b1, "R9 settled in free run", int'(settled), 1);
        wait_fall();
        bad = 0;
        for (int k = 1; k <= FREE; k++) begin
            tick(1'b0);
            if (int'(ramp) != free_ramp(k)) bad++;
        end
        chk(bad == 0, "R2 ramp slope samples", bad, 0);

        // Sync below the window is ignored
        wait_fall();
        repeat (50) tick(1'b0);
        tick(1'b1);
        wait_rise();
        chk(last_charge == FREE + 1, "R4 early sync ignored", last_charge, FREE + 1);

        // Directed lock
        run_sync(300, 40);
        chk(rise_t - prev_rise == 300, "R11 locked period", rise_t - prev_rise, 300);
        chk(iabs(last_peak - TOP) <= TOL, "R6 peak at 300", last_peak, TOP);
        chk(settled == 1'b1, "R9 settled at 300", int'(settled), 1);
        chk(iabs((BOTTOM + last_peak) / 2 - MID) <= TOL, "R8 midpoint at 300", (BOTTOM + last_peak) / 2, MID);

        // Sync during retrace
        for (int i = 0; i < 6; i++) begin
            tick(1'b1);
            repeat (5) tick(1'b0);
            tick(1'b1);
            repeat (300 - 7) tick(1'b0);
        end
        tick(1'b1);
        chk(last_ret == RT, "R5 retrace length with extra sync", last_ret, RT);
        chk(rise_t - prev_rise == 300, "R5 period with extra sync", rise_t - prev_rise, 300);
        chk(first_after == BOTTOM, "R5 restart at bottom", first_after, BOTTOM);

        // Random sync rates
        for (int r = 0; r < 5; r++) begin
            per = 140 + int'($urandom_range(260));
            sbad = 0; have_prev = 1'b0; prev_est = 0;
            for (int i = 0; i < 35; i++) begin
                run_sync(per, 1);
                if (last_peak < FULL - 1 && last_charge > 1) begin
                    est = ((last_peak - BOTTOM) * 256) / (last_charge - 1);
                    if (have_prev && iabs(est - prev_est) > MAXD + 5) sbad++;
                    prev_est = est; have_prev = 1'b1;
                end else have_prev = 1'b0;
            end
            chk(sbad == 0, "R6 per-sweep step slew", sbad, 0);
            chk(iabs(last_peak - TOP) <= TOL, "R6 peak converged", last_peak, TOP);
            chk(settled == 1'b1, "R9 settled random", int'(settled), 1);
            chk(iabs((BOTTOM + last_peak) / 2 - MID) <= TOL, "R8 midpoint random", (BOTTOM + last_peak) / 2, MID);
            chk(rise_t - prev_rise == per, "R11 period random", rise_t - prev_rise, per);
        end

        // Slow sync needs a step below the minimum
        run_sync(700, 12);
        chk(last_charge == 700 - RT, "R11 slow sync sweep", last_charge, 700 - RT);
        chk(last_peak == BOTTOM + ((last_charge - 1) * SMIN) / 256, "R7 step held at minimum",
            last_peak, BOTTOM + ((last_charge - 1) * SMIN) / 256);
        chk(settled == 1'b0, "R9 out of tolerance clears", int'(settled), 0);

        // Loss of sync
        wait_rise();
        chk(last_charge == WHI, "R10 timeout sweep length", last_charge, WHI);
        chk(settled == 1'b0, "R9 timeout clears settled", int'(settled), 0);
        wait_rise();
        chk(last_charge == FREE + 1, "R10 base step restored", last_charge, FREE + 1);
        chk(last_peak == TOP, "R10 free peak after loss", last_peak, TOP);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule